// File: doc/BRIEF.md
# Phase-Opposition Multicarrier PWM Modulator

This block drives the fourteen gates of a single-phase multilevel inverter. The inverter stacks three full H-bridges with one half-bridge whose supply is half a bridge supply, which gives thirteen output steps. A phase accumulator advances once per clock. Its top bits feed a computed parabolic sine, and that sine is the modulation reference. One shared up-counter makes a triangle. From that triangle the block derives twelve carriers, each in its own band of equal height. The six bands above zero run in mirror opposition to the six below.

The reference is compared against every carrier. The results are counted into a signed level index, and that index is registered. The index is then decoded into a drive side for each of the seven complementary switch pairs. Each pair passes through its own dead-time stage, so both of its gates are off for a chosen number of clocks before the incoming switch turns on.

In use, software-free logic sets `phase_inc` for the wanted output frequency and `dead_cycles` for the gate blanking. It then releases reset. The signed level is also brought out, for monitoring.

Top module: `pod_mcpwm`

## Requirements
- R1: A clock edge with `rst_n` low clears the phase accumulator, the carrier counter and the level register, so that `level_o` reads 0 and every bit of `gate_o` reads 0 after that edge.
- R2: The phase accumulator adds `phase_inc` at every clock, modulo 2^PH_W. Let idx be its top LUT_W bits, half be 2^(LUT_W-1), and x be idx modulo half. The reference magnitude is floor(AMP·4·x·(half−x)/half²), where AMP = 2·NB·CAR_HALF. The reference is negative when idx ≥ half.
- R3: The carrier counter runs 0 to 2·CAR_HALF−1 and then wraps. The triangle t is the count while the count is below CAR_HALF, and 2·CAR_HALF minus the count after that. For k = 0 to 2·NB−1, the upper-band carrier k is k·CAR_HALF + t and the lower-band carrier k is −k·CAR_HALF − t, so the two sides are 180° apart.
- R4: A comparator is asserted when the reference is strictly greater than its carrier. The level is the number of upper comparators asserted minus the number of lower comparators not asserted. It is registered, so `level_o` after an edge reflects the accumulator and counter values from before that edge. Its range is ±2·NB, which is 13 levels at NB = 3.
- R5: The gate for the upper switch of pair p is `gate_o[2p]` and the gate for its lower switch is `gate_o[2p+1]`. Bridge j uses pair 2j as leg A and pair 2j+1 as leg B, and pair 2·NB is the half-bridge. The half-bridge upper switch is wanted exactly when the level is odd. With b = (level − odd)/2, bridge j is positive when b > j (leg A upper, leg B lower), negative when b < −j (leg A lower, leg B upper), and otherwise shorted with both lower switches on.
- R6: The two gates of a pair are never on in the same clock.
- R7: When a pair's wanted side differs from its last committed side, both of its gates are low for `dead_cycles` clocks and the wanted side turns on in the next clock. With zero dead time the new side appears one clock after the level changes. If the request returns to the committed side before the wait ends, the committed side is restored and the opposite switch is never turned on. After reset, every pair waits `dead_cycles` clocks before its first turn-on.
- R8: Once `level_o` has held its value for `dead_cycles`+2 clocks, every pair has exactly one gate on, and 2·Σ(legA_upper − legB_upper) + halfbridge_upper equals the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_inc | input | PH_W | Phase accumulator step per clock (sets reference frequency) |
| dead_cycles | input | DEAD_W | Blanking length in clocks for every switch pair |
| level_o | output | LVL_W (signed) | Registered output level index |
| gate_o | output | 2·(2·NB+1) | Gate drives, upper/lower per pair as in R5 |

## Verification
The bench builds the block with PH_W = 16, LUT_W = 8 and CAR_HALF = 8. With these values a carrier lasts 16 clocks and the reference peaks at 48, so complete sine periods at several step sizes fit into a few hundred clocks. The bench includes a zero step, which pins the reference at zero and leaves only the one-clock dip to −1 at each carrier valley. The bench also uses dead times of 0, 1, 2, 3 and 5 clocks, which covers immediate switching, blanking over several clocks, and one-clock requests that are absorbed before the incoming switch turns on.

// File: rtl/pod_pwm_pkg.sv
package pod_pwm_pkg;

  // Parabolic sine: magnitude = amp * 4x(half-x)/half^2, with sign from the top index bit.
  function automatic int para_sine(input int idx, input int lut_w, input int amp);
    longint half;
    longint x;
    longint mag;
    half = longint'(1) << (lut_w - 1);
    x    = longint'(idx) % half;
    mag  = (longint'(amp) * x * (half - x)) >>> (2 * lut_w - 4);
    return (longint'(idx) >= half) ? -int'(mag) : int'(mag);
  endfunction

  // Whole-bridge step count that remains after the half-bridge takes an odd level.
  function automatic int bridge_steps(input int lv);
    int odd;
    odd = (lv % 2 != 0) ? 1 : 0;
    return (lv - odd) / 2;
  endfunction

  // Output in half-bridge units that a set of pair drives produces.
  function automatic int half_units(input int nb, input logic [31:0] up);
    int v;
    v = 0;
    for (int j = 0; j < nb; j++) begin
      v = v + 2 * (int'(up[2*j]) - int'(up[2*j+1]));
    end
    return v + int'(up[2*nb]);
  endfunction

endpackage

// File: rtl/pod_ref_gen.sv
module pod_ref_gen #(
  parameter int PH_W  = 32,
  parameter int LUT_W = 12,
  parameter int AMP   = 75000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PH_W-1:0]     phase_inc,
  output logic signed [31:0]  ref_o
);
  logic [PH_W-1:0]  phase_q;
  logic [LUT_W-1:0] lut_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + phase_inc;
  end

  assign lut_idx = phase_q[PH_W-1 -: LUT_W];
  assign ref_o   = pod_pwm_pkg::para_sine(int'(lut_idx), LUT_W, AMP);

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (phase_q == $past(phase_q) + $past(phase_inc)));

  assert_ref_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_o <= AMP) && (ref_o >= -AMP));
endmodule

// File: rtl/pod_carrier_gen.sv
module pod_carrier_gen #(
  parameter int CAR_HALF = 12500,
  parameter int CW       = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] tri_o
);
  localparam logic [CW-1:0] LAST = CW'(2 * CAR_HALF - 1);
  localparam logic [CW-1:0] HALF = CW'(CAR_HALF);
  localparam logic [CW-1:0] FULL = CW'(2 * CAR_HALF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tri_o = (cnt_q < HALF) ? cnt_q : (FULL - cnt_q);

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/pod_level_cmp.sv
module pod_level_cmp #(
  parameter int NBAND    = 6,
  parameter int CAR_HALF = 12500,
  parameter int CW       = 15,
  parameter int LVL_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [31:0]      ref_i,
  input  logic [CW-1:0]           tri_i,
  output logic signed [LVL_W-1:0] level_o
);
  logic [NBAND-1:0] cmp_up;
  logic [NBAND-1:0] cmp_lo;
  int               level_next;

  for (genvar k = 0; k < NBAND; k++) begin : g_band
    int car_up;
    int car_lo;
    assign car_up    = k * CAR_HALF + int'(tri_i);
    assign car_lo    = -(k * CAR_HALF) - int'(tri_i);
    assign cmp_up[k] = (ref_i > car_up);
    assign cmp_lo[k] = (ref_i > car_lo);
  end

  always_comb begin
    level_next = $countones(cmp_up) - (NBAND - $countones(cmp_lo));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_o <= '0;
    else        level_o <= LVL_W'(level_next);
  end

  // upper carriers rise with k, so a higher band may fire only if all lower ones do
  assert_thermo_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_up[NBAND-1:1] & ~cmp_up[NBAND-2:0]) == '0);

  assert_thermo_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo[NBAND-2:0] & ~cmp_lo[NBAND-1:1]) == '0);

  assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level_o) <= NBAND) && (int'(level_o) >= -NBAND));
endmodule

// File: rtl/pod_gate_decode.sv
module pod_gate_decode #(
  parameter int NB    = 3,
  parameter int LVL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [2*NB:0]           want_up_o
);
  int lv;
  int steps;
  int volts;

  always_comb begin
    lv    = int'(level_i);
    steps = pod_pwm_pkg::bridge_steps(lv);
    want_up_o[2*NB] = (lv % 2 != 0);
    for (int j = 0; j < NB; j++) begin
      want_up_o[2*j]   = (steps > j);
      want_up_o[2*j+1] = (steps < -j);
    end
  end

  always_comb begin
    volts = pod_pwm_pkg::half_units(NB, 32'(want_up_o));
  end

  assert_volts_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    volts == lv);

  assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (want_up_o[0] & want_up_o[1]) == 1'b0);
endmodule

// File: rtl/pod_deadtime.sv
module pod_deadtime #(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic              want_up_i,
  output logic              hi_o,
  output logic              lo_o
);
  logic              own_q;
  logic              armed_q;
  logic [DEAD_W-1:0] hold_q;
  logic              settled;
  logic              hold_done;

  assign settled   = armed_q && (want_up_i == own_q);
  assign hold_done = (hold_q >= dead_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q   <= 1'b0;
      armed_q <= 1'b0;
      hold_q  <= '0;
      hi_o    <= 1'b0;
      lo_o    <= 1'b0;
    end else if (settled) begin
      hi_o   <= own_q;
      lo_o   <= !own_q;
      hold_q <= '0;
    end else if (hold_done) begin
      own_q   <= want_up_i;
      armed_q <= 1'b1;
      hi_o    <= want_up_i;
      lo_o    <= !want_up_i;
      hold_q  <= '0;
    end else begin
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
      hold_q <= hold_q + 1'b1;
    end
  end

  assert_pair_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_o && lo_o));

  assert_gap_hi_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_o && dead_i != '0) |=> !lo_o);

  assert_gap_lo_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_o && dead_i != '0) |=> !hi_o);
endmodule

// File: rtl/pod_mcpwm.sv
module pod_mcpwm #(
  parameter int NB       = 3,
  parameter int PH_W     = 32,
  parameter int LUT_W    = 12,
  parameter int CAR_HALF = 12500,
  parameter int DEAD_W   = 8,
  localparam int NBAND   = 2 * NB,
  localparam int NPAIR   = 2 * NB + 1,
  localparam int NGATE   = 2 * NPAIR,
  localparam int LVL_W   = $clog2(NBAND + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PH_W-1:0]         phase_inc,
  input  logic [DEAD_W-1:0]       dead_cycles,
  output logic signed [LVL_W-1:0] level_o,
  output logic [NGATE-1:0]        gate_o
);
  localparam int AMP = NBAND * CAR_HALF;
  localparam int CW  = $clog2(2 * CAR_HALF + 1);

  logic signed [31:0] ref_w;
  logic [CW-1:0]      tri_w;
  logic [NPAIR-1:0]   want_up;

  pod_ref_gen #(.PH_W(PH_W), .LUT_W(LUT_W), .AMP(AMP)) u_ref (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .ref_o(ref_w)
  );

  pod_carrier_gen #(.CAR_HALF(CAR_HALF), .CW(CW)) u_car (
    .clk(clk), .rst_n(rst_n), .tri_o(tri_w)
  );

  pod_level_cmp #(.NBAND(NBAND), .CAR_HALF(CAR_HALF), .CW(CW), .LVL_W(LVL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_w), .tri_i(tri_w), .level_o(level_o)
  );

  pod_gate_decode #(.NB(NB), .LVL_W(LVL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .level_i(level_o), .want_up_o(want_up)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pod_deadtime #(.DEAD_W(DEAD_W)) u_dt (
      .clk(clk), .rst_n(rst_n), .dead_i(dead_cycles), .want_up_i(want_up[p]),
      .hi_o(gate_o[2*p]), .lo_o(gate_o[2*p+1])
    );
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (gate_o == '0 && level_o == '0));
endmodule

// File: tb/tb_pod_mcpwm.sv
module tb_pod_mcpwm;
  localparam int NB       = 3;
  localparam int PH_W     = 16;
  localparam int LUT_W    = 8;
  localparam int CAR_HALF = 8;
  localparam int DEAD_W   = 4;
  localparam int NBAND    = 2 * NB;
  localparam int NPAIR    = 2 * NB + 1;
  localparam int NGATE    = 2 * NPAIR;
  localparam int LVL_W    = 4;
  localparam int AMP      = NBAND * CAR_HALF;

  logic clk = 1'b0;
  logic rst_n;
  logic [PH_W-1:0] phase_inc;
  logic [DEAD_W-1:0] dead_cycles;
  logic signed [LVL_W-1:0] level_o;
  logic [NGATE-1:0] gate_o;

  always #4 clk = ~clk;

  pod_mcpwm #(.NB(NB), .PH_W(PH_W), .LUT_W(LUT_W), .CAR_HALF(CAR_HALF), .DEAD_W(DEAD_W)) dut (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .dead_cycles(dead_cycles),
    .level_o(level_o), .gate_o(gate_o)
  );

  typedef struct {
    int               lvl;
    logic [NGATE-1:0] g;
    bit               rst;
    bit               pend;
    int               dead;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  int m_ph, m_cnt, m_lvl;
  int side[NPAIR];
  int commit[NPAIR];
  int age[NPAIR];
  bit have[NPAIR];

  function automatic int ref_model(input int ph);
    int idx, half, x;
    longint mag;
    idx  = ph >> (PH_W - LUT_W);
    half = 1 << (LUT_W - 1);
    x    = (idx >= half) ? idx - half : idx;
    mag  = (longint'(AMP) * 4 * x * (half - x)) / (longint'(half) * half);
    return (idx >= half) ? -int'(mag) : int'(mag);
  endfunction

  function automatic int level_model(input int r, input int cnt);
    int t, u, s, up, off;
    t = (cnt < CAR_HALF) ? cnt : 2 * CAR_HALF - cnt;
    u = r - t;
    up = (u > 0) ? (u - 1) / CAR_HALF + 1 : 0;
    if (up > NBAND) up = NBAND;
    s = -(r + t);
    off = (s >= 0) ? s / CAR_HALF + 1 : 0;
    if (off > NBAND) off = NBAND;
    return up - off;
  endfunction

  function automatic bit want_model(input int lvl, input int p);
    bit odd;
    int b;
    odd = (lvl % 2 != 0);
    b = (lvl - int'(odd)) / 2;
    if (p == NPAIR - 1) return odd;
    if (p % 2 == 0) return b > p / 2;
    return b < -(p / 2);
  endfunction

  task automatic push_expected();
    exp_t e;
    int nl;
    e.pend = 0;
    e.dead = int'(dead_cycles);
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_lvl = 0;
      for (int p = 0; p < NPAIR; p++) begin
        side[p] = 0; commit[p] = 0; age[p] = 0; have[p] = 0;
      end
      e.rst = 1;
    end else begin
      nl = level_model(ref_model(m_ph), m_cnt);
      for (int p = 0; p < NPAIR; p++) begin
        bit w;
        w = want_model(m_lvl, p);
        if (have[p] && int'(w) == commit[p]) begin
          side[p] = w ? 1 : 2; age[p] = 0;
        end else if (age[p] >= int'(dead_cycles)) begin
          commit[p] = int'(w); have[p] = 1; side[p] = w ? 1 : 2; age[p] = 0;
        end else begin
          side[p] = 0; age[p]++; e.pend = 1;
        end
      end
      m_ph  = (m_ph + int'(phase_inc)) % (1 << PH_W);
      m_cnt = (m_cnt + 1) % (2 * CAR_HALF);
      m_lvl = nl;
      e.rst = 0;
    end
    e.lvl = m_lvl;
    for (int p = 0; p < NPAIR; p++) begin
      e.g[2*p]   = (side[p] == 1);
      e.g[2*p+1] = (side[p] == 2);
    end
    sb.push_back(e);
  endtask

  always @(posedge clk) push_expected();

  int stable = 0;
  int prev_lvl = 0;

  task automatic monitor_step();
    exp_t e;
    int v, ones;
    bit all_one;
    if (sb.size() == 0) return;
    e = sb.pop_front();
    // R1 on reset items, otherwise level pipeline R2/R3/R4
    checks++;
    if (int'(level_o) != e.lvl) begin
      failures++;
      $display("FAIL %s level actual=%0d expected=%0d", e.rst ? "R1" : "R2/R3/R4",
               int'(level_o), e.lvl);
    end
    checks++;
    if (gate_o !== e.g) begin
      failures++;
      $display("FAIL %s gates actual=%b expected=%b",
               e.rst ? "R1" : (e.pend ? "R7" : "R5"), gate_o, e.g);
    end
    // R6: never both gates of a pair
    checks++;
    for (int p = 0; p < NPAIR; p++) begin
      if (gate_o[2*p] && gate_o[2*p+1]) begin
        failures++;
        $display("FAIL R6 pair %0d actual=11 expected=not both", p);
        break;
      end
    end
    if (e.rst) stable = 0;
    else if (int'(level_o) == prev_lvl) stable++;
    else stable = 1;
    prev_lvl = int'(level_o);
    // R8: settled output sums to the level
    if (!e.rst && stable >= e.dead + 2) begin
      all_one = 1; v = 0;
      for (int p = 0; p < NPAIR; p++) begin
        ones = int'(gate_o[2*p]) + int'(gate_o[2*p+1]);
        if (ones != 1) all_one = 0;
      end
      for (int j = 0; j < NB; j++) v += 2 * (int'(gate_o[4*j]) - int'(gate_o[4*j+2]));
      v += int'(gate_o[4*NB]);
      checks++;
      if (!all_one || v != int'(level_o)) begin
        failures++;
        $display("FAIL R8 half-units actual=%0d expected=%0d", v, int'(level_o));
      end
    end
  endtask

  always @(negedge clk) monitor_step();

  task automatic run_case(input int inc, input int dd, input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    dead_cycles = DEAD_W'(dd);
    phase_inc = PH_W'(inc);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    phase_inc = '0;
    dead_cycles = DEAD_W'(2);
    repeat (4) @(negedge clk);
    run_case(0, 2, 64);       // R7 absorbed one-clock request, reference at zero
    run_case(300, 2, 700);    // R2 R3 R4 full sine periods
    run_case(1000, 0, 400);   // R5 R7 zero dead time
    run_case(77, 5, 1800);    // R8 slow reference, long blanking
    run_case(30000, 1, 200);  // R4 large steps across bands
    run_case(655, 3, 600);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule